// File: doc/BRIEF.md
# Decode-Stage Branch Resolver

This block decides, in the second stage of a five-stage in-order pipeline, whether the branch now being decoded is taken. It also owns the fetch address register. The register file has already been read, so the block receives the branch target value and the condition value as operands, together with the stage-2 instruction word. Each cycle the fetch address moves forward by one word. A taken branch replaces that step with the target value, so the new address is first seen by the fetch after the next clock edge.

The instruction fetched while the branch sits in stage 2 is not cancelled. That instruction is the delay slot, and it always executes. The linking form of the branch records a return address equal to the fetch address during its decode cycle plus one word. It carries that address and the destination register index through the three later stages, and presents them as a register write request at stage 5. The plain form never writes a register. A stall holds the fetch address, blocks any redirect, and sends a bubble in place of the link entry.

Top module: `brunit_top`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are `pc_o` = 0, `taken_o` = 0 and `link_we_o` = 0.
- R2: In a cycle with no stall and no taken branch, `pc_o` increases by 4 at the next edge and `taken_o` is 0.
- R3: A taken branch in stage 2 (opcode `ir2_i[31:27]` equal to 8 or 9, with no stall) sets `pc_o` to `target_i` and `taken_o` to 1 at the next edge. Condition code `ir2_i[2:0]` = 1 is always taken.
- R4: With condition bits `[2:1]` = 1, the branch is taken when `ir2_i[0]` XOR (`cond_i` == 0) is 0. Code 2 is taken when the value is nonzero, and code 3 is taken when it is zero.
- R5: With condition bits `[2:1]` = 2, the branch is taken when `ir2_i[0]` XOR `cond_i[31]` is 1. Code 4 is taken when the value is negative, and code 5 is taken when it is non-negative.
- R6: Condition codes 0, 6 and 7 are never taken, whatever `cond_i` holds.
- R7: An instruction whose opcode is neither 8 nor 9 never redirects, whatever its low bits hold.
- R8: While `stall` is high, `pc_o` holds its value, `taken_o` is 0 at the next edge, and no link entry enters the pipeline.
- R9: Delay slot: the fetch address during the branch's stage-2 cycle is the sequential one. The redirect shows on `pc_o` only after the edge.
- R10: The linking form (opcode 9) produces exactly one `link_we_o` pulse, three edges after it resolves. The pulse carries `link_o` = decode-cycle `pc_o` + 4 and `link_rd_o` = `ir2_i[26:22]`, and it occurs whether or not the branch is taken.
- R11: The plain form (opcode 8) never raises `link_we_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Holds fetch address, suppresses redirect, bubbles link pipe |
| ir2_i | input | 32 | Instruction word in stage 2 |
| target_i | input | 32 | Branch target operand |
| cond_i | input | 32 | Condition operand |
| pc_o | output | 32 | Registered fetch address |
| taken_o | output | 1 | Registered: last update was a redirect |
| link_we_o | output | 1 | Stage-5 link write request |
| link_rd_o | output | 5 | Stage-5 link destination index |
| link_o | output | 32 | Stage-5 link value |

## Verification
The fetch address and the taken flag are due one edge after the instruction is presented. The bench therefore drives each stimulus just after an edge and reads these outputs one time unit after the following edge. The link request is due three edges after resolution. The bench checks that it is low after the first and second of those edges, high with the expected value after the third, and low again after the fourth. Delay-slot behaviour is checked by reading `pc_o` after a taken branch is applied but before the edge, where it must still hold the sequential address.

// File: rtl/brunit_pkg.sv
package brunit_pkg;
  typedef enum logic [1:0] {TST_NONE, TST_ALWAYS, TST_ZERO, TST_SIGN} test_kind_e;

  // Condition field -> test kind; codes 0,6,7 never fire
  function automatic test_kind_e decode_test(input logic [2:0] code);
    test_kind_e k;
    case (code[2:1])
      2'd0:    k = code[0] ? TST_ALWAYS : TST_NONE;
      2'd1:    k = TST_ZERO;
      2'd2:    k = TST_SIGN;
      default: k = TST_NONE;
    endcase
    return k;
  endfunction
endpackage

// File: rtl/brunit_cond.sv
module brunit_cond
  import brunit_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int OPW    = 5,
  parameter logic [OPW-1:0] OP_BR  = 5'd8,
  parameter logic [OPW-1:0] OP_BRL = 5'd9
) (
  input  logic [XLEN-1:0] ir,
  input  logic [XLEN-1:0] cond_val,
  output logic            is_link,
  output logic            take
);
  logic [OPW-1:0] opcode;
  logic           is_branch;
  logic           is_zero;
  logic           is_neg;
  logic           hit;
  test_kind_e     kind;

  assign opcode    = ir[XLEN-1 -: OPW];
  assign is_link   = (opcode == OP_BRL);
  assign is_branch = (opcode == OP_BR) || is_link;
  assign is_zero   = (cond_val == '0);
  assign is_neg    = cond_val[XLEN-1];
  assign kind      = decode_test(ir[2:0]);

  always_comb begin
    case (kind)
      TST_ALWAYS: hit = 1'b1;
      TST_ZERO:   hit = ~(ir[0] ^ is_zero);
      TST_SIGN:   hit = ir[0] ^ is_neg;
      default:    hit = 1'b0;
    endcase
  end

  assign take = is_branch & hit;
endmodule

// File: rtl/brunit_pc.sv
module brunit_pc #(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            stall,
  input  logic            take,
  input  logic [XLEN-1:0] target,
  output logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] pc_seq,
  output logic            redirected
);
  localparam logic [XLEN-1:0] STEP = XLEN'(XLEN / 8);

  assign pc_seq = pc + STEP;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc         <= RESET_PC;
      redirected <= 1'b0;
    end else if (stall) begin
      redirected <= 1'b0;
    end else begin
      pc         <= take ? target : pc_seq;
      redirected <= take;
    end
  end
endmodule

// File: rtl/brunit_linkpipe.sv
module brunit_linkpipe #(
  parameter int XLEN  = 32,
  parameter int RW    = 5,
  parameter int DEPTH = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [RW-1:0]   in_rd,
  input  logic [XLEN-1:0] in_data,
  output logic            out_valid,
  output logic [RW-1:0]   out_rd,
  output logic [XLEN-1:0] out_data
);
  logic [DEPTH-1:0] v_q;
  logic [RW-1:0]    rd_q [DEPTH];
  logic [XLEN-1:0]  d_q  [DEPTH];

  genvar i;
  generate
    for (i = 0; i < DEPTH; i++) begin : g_stage
      if (i == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (rst) v_q[0] <= 1'b0;
          else     v_q[0] <= in_valid;
          rd_q[0] <= in_rd;
          d_q[0]  <= in_data;
        end
      end else begin : g_body
        always_ff @(posedge clk) begin
          if (rst) v_q[i] <= 1'b0;
          else     v_q[i] <= v_q[i-1];
          rd_q[i] <= rd_q[i-1];
          d_q[i]  <= d_q[i-1];
        end
      end
    end
  endgenerate

  assign out_valid = v_q[DEPTH-1];
  assign out_rd    = rd_q[DEPTH-1];
  assign out_data  = d_q[DEPTH-1];
endmodule

// File: rtl/brunit_top.sv
module brunit_top #(
  parameter int XLEN = 32,
  parameter int OPW  = 5,
  parameter int RW   = 5,
  parameter int LINK_STAGES = 3,
  parameter logic [OPW-1:0] OP_BR  = 5'd8,
  parameter logic [OPW-1:0] OP_BRL = 5'd9,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            stall,
  input  logic [XLEN-1:0] ir2_i,
  input  logic [XLEN-1:0] target_i,
  input  logic [XLEN-1:0] cond_i,
  output logic [XLEN-1:0] pc_o,
  output logic            taken_o,
  output logic            link_we_o,
  output logic [RW-1:0]   link_rd_o,
  output logic [XLEN-1:0] link_o
);
  localparam int RD_LSB = XLEN - OPW - RW;

  logic            br_take;
  logic            br_link;
  logic [XLEN-1:0] pc_seq;

  brunit_cond #(.XLEN(XLEN), .OPW(OPW), .OP_BR(OP_BR), .OP_BRL(OP_BRL)) u_cond (
    .ir(ir2_i), .cond_val(cond_i), .is_link(br_link), .take(br_take)
  );

  brunit_pc #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_pc (
    .clk(clk), .rst(rst), .stall(stall), .take(br_take), .target(target_i),
    .pc(pc_o), .pc_seq(pc_seq), .redirected(taken_o)
  );

  brunit_linkpipe #(.XLEN(XLEN), .RW(RW), .DEPTH(LINK_STAGES)) u_link (
    .clk(clk), .rst(rst), .in_valid(br_link & ~stall),
    .in_rd(ir2_i[RD_LSB +: RW]), .in_data(pc_seq),
    .out_valid(link_we_o), .out_rd(link_rd_o), .out_data(link_o)
  );
endmodule

// File: rtl/brunit_chk.sv
module brunit_chk #(
  parameter int XLEN = 32,
  parameter int OPW  = 5,
  parameter logic [OPW-1:0] OP_BR  = 5'd8,
  parameter logic [OPW-1:0] OP_BRL = 5'd9,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input logic            clk,
  input logic            rst,
  input logic            stall,
  input logic [XLEN-1:0] ir2_i,
  input logic [XLEN-1:0] target_i,
  input logic [XLEN-1:0] pc_o,
  input logic            taken_o,
  input logic            link_we_o,
  input logic            br_take
);
  localparam logic [XLEN-1:0] STEP = XLEN'(XLEN / 8);
  logic [OPW-1:0] op;
  assign op = ir2_i[XLEN-1 -: OPW];

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (pc_o == RESET_PC && !taken_o && !link_we_o));

  a_r2_seq_step: assert property (@(posedge clk) disable iff (rst)
    (!stall && !br_take) |=> (pc_o == $past(pc_o) + STEP && !taken_o));

  a_r3_redirect: assert property (@(posedge clk) disable iff (rst)
    (!stall && br_take) |=> (taken_o && pc_o == $past(target_i)));

  a_r6_never_codes: assert property (@(posedge clk) disable iff (rst)
    (ir2_i[2:0] == 3'd0 || ir2_i[2:1] == 2'd3) |=> !taken_o);

  a_r7_non_branch: assert property (@(posedge clk) disable iff (rst)
    (op != OP_BR && op != OP_BRL) |=> !taken_o);

  a_r8_stall_hold: assert property (@(posedge clk) disable iff (rst)
    stall |=> ($stable(pc_o) && !taken_o));
endmodule

bind brunit_top brunit_chk #(
  .XLEN(XLEN), .OPW(OPW), .OP_BR(OP_BR), .OP_BRL(OP_BRL), .RESET_PC(RESET_PC)
) u_chk (
  .clk(clk), .rst(rst), .stall(stall), .ir2_i(ir2_i), .target_i(target_i),
  .pc_o(pc_o), .taken_o(taken_o), .link_we_o(link_we_o), .br_take(br_take)
);

// File: tb/brunit_top_test.sv
module brunit_top_test;
  localparam int PERIOD = 10;
  localparam logic [4:0] OPB = 5'd8, OPL = 5'd9, OPN = 5'd3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stall = 1'b0;
  logic [31:0] ir2 = '0, tgt = '0, cnd = '0;
  logic [31:0] pc_o, link_o;
  logic        taken_o, link_we_o;
  logic [4:0]  link_rd_o;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  brunit_top uut (
    .clk(clk), .rst(rst), .stall(stall), .ir2_i(ir2), .target_i(tgt), .cond_i(cnd),
    .pc_o(pc_o), .taken_o(taken_o), .link_we_o(link_we_o), .link_rd_o(link_rd_o), .link_o(link_o)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [31:0] mk(input logic [4:0] op, input logic [4:0] rd, input logic [2:0] code);
    return {op, rd, 19'd0, code};
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one branch attempt; expect_take decides next pc
  task automatic t_branch(input string req, input logic [4:0] op, input logic [2:0] code,
                          input logic [31:0] cv, input bit expect_take);
    logic [31:0] base = pc_o;
    ir2 = mk(op, 5'd1, code); cnd = cv; tgt = 32'h0000_0800 + {24'd0, code, 5'd0};
    tick();
    chk({req, " pc"}, pc_o, expect_take ? tgt : base + 4);
    chk({req, " taken"}, {31'd0, taken_o}, {31'd0, expect_take});
    ir2 = mk(OPN, 5'd0, 3'd0);
  endtask

  task automatic t_reset();
    chk("R1 pc", pc_o, 32'd0);
    chk("R1 taken", {31'd0, taken_o}, 32'd0);
    chk("R1 link_we", {31'd0, link_we_o}, 32'd0);
  endtask

  task automatic t_seq();
    for (int i = 0; i < 3; i++) begin
      logic [31:0] b = pc_o;
      tick();
      chk("R2 step", pc_o, b + 4);
      chk("R2 taken", {31'd0, taken_o}, 32'd0);
    end
  endtask

  task automatic t_delay_slot();
    logic [31:0] b = pc_o;
    ir2 = mk(OPB, 5'd0, 3'd1); tgt = 32'h0000_1230;
    #1;
    chk("R9 slot addr unchanged before edge", pc_o, b);
    tick();
    chk("R9 redirect after edge", pc_o, 32'h0000_1230);
    ir2 = mk(OPN, 5'd0, 3'd0);
    tick();
    chk("R9 continues from target", pc_o, 32'h0000_1234);
  endtask

  task automatic t_stall();
    logic [31:0] b = pc_o;
    stall = 1'b1; ir2 = mk(OPB, 5'd0, 3'd1); tgt = 32'h0000_4000;
    tick();
    chk("R8 pc held", pc_o, b);
    chk("R8 no taken", {31'd0, taken_o}, 32'd0);
    tick();
    chk("R8 pc held 2", pc_o, b);
    stall = 1'b0;
    tick();
    chk("R8 resolves after release", pc_o, 32'h0000_4000);
    ir2 = mk(OPN, 5'd0, 3'd0);
  endtask

  task automatic t_link(input string req, input logic [2:0] code, input logic [31:0] cv, input bit tk);
    logic [31:0] b = pc_o;
    ir2 = mk(OPL, 5'd9, code); cnd = cv; tgt = 32'h0000_2000;
    tick();
    chk({req, " pc"}, pc_o, tk ? 32'h0000_2000 : b + 4);
    ir2 = mk(OPN, 5'd0, 3'd0);
    chk({req, " we edge1"}, {31'd0, link_we_o}, 32'd0);
    tick();
    chk({req, " we edge2"}, {31'd0, link_we_o}, 32'd0);
    tick();
    chk({req, " we edge3"}, {31'd0, link_we_o}, 32'd1);
    chk({req, " link value"}, link_o, b + 4);
    chk({req, " link rd"}, {27'd0, link_rd_o}, 32'd9);
    tick();
    chk({req, " single pulse"}, {31'd0, link_we_o}, 32'd0);
  endtask

  task automatic t_plain_nolink();
    int pulses = 0;
    ir2 = mk(OPB, 5'd7, 3'd1); tgt = 32'h0000_3000;
    tick();
    ir2 = mk(OPN, 5'd0, 3'd0);
    for (int i = 0; i < 5; i++) begin
      if (link_we_o) pulses++;
      tick();
    end
    chk("R11 plain branch link pulses", pulses, 0);
  endtask

  task automatic t_stall_link();
    int pulses = 0;
    stall = 1'b1; ir2 = mk(OPL, 5'd4, 3'd0);
    tick(); tick();
    stall = 1'b0;
    tick();
    ir2 = mk(OPN, 5'd0, 3'd0);
    for (int i = 0; i < 6; i++) begin
      if (link_we_o) pulses++;
      tick();
    end
    chk("R8 stall bubbles link (one pulse)", pulses, 1);
  endtask

  initial begin
    ir2 = mk(OPN, 5'd0, 3'd0);
    tick(); tick();
    t_reset();
    rst = 1'b0;
    t_seq();
    t_branch("R3 always", OPB, 3'd1, 32'd0, 1'b1);
    t_branch("R4 code2 nonzero", OPB, 3'd2, 32'd5, 1'b1);
    t_branch("R4 code2 zero", OPB, 3'd2, 32'd0, 1'b0);
    t_branch("R4 code3 zero", OPB, 3'd3, 32'd0, 1'b1);
    t_branch("R4 code3 nonzero", OPB, 3'd3, 32'h8000_0000, 1'b0);
    t_branch("R5 code4 negative", OPB, 3'd4, 32'hFFFF_FFFF, 1'b1);
    t_branch("R5 code4 positive", OPB, 3'd4, 32'd7, 1'b0);
    t_branch("R5 code5 zero", OPB, 3'd5, 32'd0, 1'b1);
    t_branch("R5 code5 negative", OPB, 3'd5, 32'h8000_0000, 1'b0);
    t_branch("R6 code0", OPB, 3'd0, 32'd0, 1'b0);
    t_branch("R6 code6", OPB, 3'd6, 32'hFFFF_FFFF, 1'b0);
    t_branch("R6 code7", OPL, 3'd7, 32'd1, 1'b0);
    t_branch("R7 non-branch opcode", OPN, 3'd1, 32'd0, 1'b0);
    t_branch("R7 opcode 0", 5'd0, 3'd3, 32'd0, 1'b0);
    t_delay_slot();
    t_stall();
    t_link("R10 link taken", 3'd1, 32'd0, 1'b1);
    t_link("R10 link not taken", 3'd0, 32'd0, 1'b0);
    t_plain_nolink();
    t_stall_link();
    rst = 1'b1;
    tick();
    t_reset();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule